// File: doc/BRIEF.md
# Radar Chirp Frame Sequencer

This block steps a pulsed radar transmitter through one frame at a time. A start request taken while idle opens a frame. The frame first runs a burst of long chirps, each followed by a long listen window. A guard interval comes next. Then a burst of short chirps runs, each followed by its own short listen window. The block then signals completion for one cycle and goes back to idle. Each duration is a cycle-count parameter. The block shows its current state code and a 6-bit chirp counter, and downstream waveform, RF and receive logic decode both.

The chirp counter is cleared as each frame finishes. A later frame started without a reset therefore runs the same number of long and short chirps as the first frame, and the counter never runs on toward wrap-around.

Top module: `chirp_frame_seq`

## Requirements
- R1: While reset is asserted and on its release, `state_o` reads 3'b000 (idle) and `chirp_cnt_o` reads 0.
- R2: When `new_chirp_i` is high on a clock edge while the state is idle, the state becomes 3'b001 (long chirp) on that edge.
- R3: The long chirp state (3'b001) lasts T1_SAMPLES cycles and the long listen state (3'b010) lasts T1_RADAR_LISTENING cycles. The counter increments by one at the end of each long listen window, so the k-th long pair shows count k-1.
- R4: When a long listen window ends with the counter at CHIRP_MAX/2-1, the state moves to guard (3'b011). The guard lasts GUARD_SAMPLES cycles and the counter reads CHIRP_MAX/2 throughout.
- R5: The short chirp state (3'b100) lasts T2_SAMPLES cycles and the short listen state (3'b101) lasts T2_RADAR_LISTENING cycles. The counter increments at the end of each short listen window. The short phase ends when a short listen window ends with the counter at CHIRP_MAX-1, so CHIRP_MAX/2 short chirps are run.
- R6: The done state (3'b110) lasts exactly one cycle and shows the count CHIRP_MAX. The next cycle is idle with the counter at 0.
- R7: `new_chirp_i` has no effect in any state other than idle.
- R8: A frame started from idle without a reset, including one started right after the first idle cycle, repeats the first frame cycle for cycle in both state and count.
- R9: The state stays idle and the count stays 0 for as long as `new_chirp_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| new_chirp_i | input | 1 | Frame start request, taken only in idle |
| state_o | output | 3 | Current state code |
| chirp_cnt_o | output | 6 | Chirp counter |

## Verification
The state register is the only stage between the start request and the outputs. The clock edge that samples `new_chirp_i` high in idle therefore shows 3'b001 at once. From that edge the bench numbers every cycle by its offset k. It computes the expected state and count for each k from the duration parameters alone: done falls at k equal to the summed frame length and idle at the next k. The bench samples both outputs 2 ns after every rising edge and drives inputs only after sampling. Each sample therefore reflects exactly one more edge, and each frame is compared cycle by cycle across three frames that hold the request high, toggle it, or keep it low.

// File: rtl/chirp_seq_pkg.sv
package chirp_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'b000,
    ST_LCHIRP  = 3'b001,
    ST_LLISTEN = 3'b010,
    ST_GUARD   = 3'b011,
    ST_SCHIRP  = 3'b100,
    ST_SLISTEN = 3'b101,
    ST_DONE    = 3'b110
  } seq_state_e;
endpackage

// File: rtl/seq_dur_sel.sv
module seq_dur_sel
  import chirp_seq_pkg::*;
#(
  parameter int TW                 = 16,
  parameter int T1_SAMPLES         = 60,
  parameter int T1_RADAR_LISTENING = 200,
  parameter int GUARD_SAMPLES      = 40,
  parameter int T2_SAMPLES         = 10,
  parameter int T2_RADAR_LISTENING = 100
) (
  input  seq_state_e    state_i,
  output logic [TW-1:0] dur_o
);
  always_comb begin
    unique case (state_i)
      ST_LCHIRP:  dur_o = TW'(T1_SAMPLES);
      ST_LLISTEN: dur_o = TW'(T1_RADAR_LISTENING);
      ST_GUARD:   dur_o = TW'(GUARD_SAMPLES);
      ST_SCHIRP:  dur_o = TW'(T2_SAMPLES);
      ST_SLISTEN: dur_o = TW'(T2_RADAR_LISTENING);
      default:    dur_o = TW'(1);
    endcase
  end
endmodule

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [TW-1:0] dur_i,
  output logic          last_o
);
  logic [TW-1:0] tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tmr_q <= '0;
    else if (!run_i) tmr_q <= '0;
    else             tmr_q <= tmr_q + TW'(1);
  end

  assign last_o = (tmr_q == dur_i - TW'(1));

  // R3/R5: a state dwell never outruns its duration
  a_r3_timer_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_q < dur_i);
endmodule

// File: rtl/seq_chirp_cnt.sv
module seq_chirp_cnt #(
  parameter int CW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + CW'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/chirp_frame_seq.sv
module chirp_frame_seq
  import chirp_seq_pkg::*;
#(
  parameter int CHIRP_MAX          = 32,
  parameter int TW                 = 16,
  parameter int T1_SAMPLES         = 60,
  parameter int T1_RADAR_LISTENING = 200,
  parameter int GUARD_SAMPLES      = 40,
  parameter int T2_SAMPLES         = 10,
  parameter int T2_RADAR_LISTENING = 100
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       new_chirp_i,
  output logic [2:0] state_o,
  output logic [5:0] chirp_cnt_o
);
  localparam int CW = 6;
  localparam logic [CW-1:0] HALF    = CW'(CHIRP_MAX / 2);
  localparam logic [CW-1:0] HALF_M1 = CW'(CHIRP_MAX / 2 - 1);
  localparam logic [CW-1:0] FULL_M1 = CW'(CHIRP_MAX - 1);

  seq_state_e    state_q, state_d;
  logic [TW-1:0] dur;
  logic          last, timed, run, cnt_inc, cnt_clr;
  logic [CW-1:0] cnt;

  seq_dur_sel #(
    .TW(TW), .T1_SAMPLES(T1_SAMPLES), .T1_RADAR_LISTENING(T1_RADAR_LISTENING),
    .GUARD_SAMPLES(GUARD_SAMPLES), .T2_SAMPLES(T2_SAMPLES),
    .T2_RADAR_LISTENING(T2_RADAR_LISTENING)
  ) u_dur (
    .state_i(state_q),
    .dur_o  (dur)
  );

  seq_timer #(.TW(TW)) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .dur_i (dur),
    .last_o(last)
  );

  seq_chirp_cnt #(.CW(CW)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .inc_i (cnt_inc),
    .cnt_o (cnt)
  );

  assign timed = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign run   = timed && (state_d == state_q);

  always_comb begin
    state_d = state_q;
    cnt_inc = 1'b0;
    cnt_clr = 1'b0;
    unique case (state_q)
      ST_IDLE:    if (new_chirp_i) state_d = ST_LCHIRP;
      ST_LCHIRP:  if (last) state_d = ST_LLISTEN;
      ST_LLISTEN: if (last) begin
        cnt_inc = 1'b1;
        state_d = (cnt == HALF_M1) ? ST_GUARD : ST_LCHIRP;
      end
      ST_GUARD:   if (last) state_d = ST_SCHIRP;
      ST_SCHIRP:  if (last) state_d = ST_SLISTEN;
      ST_SLISTEN: if (last) begin
        cnt_inc = 1'b1;
        state_d = (cnt == FULL_M1) ? ST_DONE : ST_SCHIRP;
      end
      ST_DONE: begin
        cnt_clr = 1'b1;  // frame end: next frame starts from zero
        state_d = ST_IDLE;
      end
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o     = state_q;
  assign chirp_cnt_o = cnt;

  // R2: request in idle starts the long burst on the next edge
  a_r2_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && new_chirp_i) |=> (state_o == 3'b001));
  // R3: counter moves only at a listen end or at done
  a_r3_cnt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q inside {ST_IDLE, ST_LCHIRP, ST_GUARD, ST_SCHIRP}) |=> $stable(chirp_cnt_o));
  // R4: guard entered with half count
  a_r4_guard_cnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LLISTEN && state_d == ST_GUARD) |=> (chirp_cnt_o == HALF));
  // R6: done is one cycle and leaves a zero count
  a_r6_done_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE) |=> (state_o == 3'b000 && chirp_cnt_o == '0));
  // R9: idle holds while no request
  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !new_chirp_i) |=> (state_o == 3'b000));
endmodule

// File: tb/chirp_frame_seq_test.sv
module chirp_frame_seq_test;
  localparam int CMAX = 6;
  localparam int HALF = CMAX / 2;
  localparam int T1 = 3, T1L = 4, GRD = 5, T2 = 2, T2L = 3;
  localparam int LP = T1 + T1L;
  localparam int SP = T2 + T2L;
  localparam int FLEN = HALF * LP + GRD + HALF * SP;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       new_chirp = 1'b0;
  logic [2:0] state;
  logic [5:0] cnt;
  int n_chk = 0, n_bad = 0;
  bit fin = 0;

  chirp_frame_seq #(
    .CHIRP_MAX(CMAX), .TW(8), .T1_SAMPLES(T1), .T1_RADAR_LISTENING(T1L),
    .GUARD_SAMPLES(GRD), .T2_SAMPLES(T2), .T2_RADAR_LISTENING(T2L)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .new_chirp_i(new_chirp),
    .state_o(state), .chirp_cnt_o(cnt)
  );

  always #4 clk = ~clk;

  // expected {state,count} at offset k from long-chirp entry
  function automatic logic [8:0] exp_at(int k);
    int r, i;
    if (k < HALF * LP) begin
      i = k / LP; r = k % LP;
      return {(r < T1) ? 3'b001 : 3'b010, 6'(i)};
    end
    k -= HALF * LP;
    if (k < GRD) return {3'b011, 6'(HALF)};
    k -= GRD;
    if (k < HALF * SP) begin
      i = k / SP; r = k % SP;
      return {(r < T2) ? 3'b100 : 3'b101, 6'(HALF + i)};
    end
    if (k == HALF * SP) return {3'b110, 6'(CMAX)};
    return {3'b000, 6'd0};
  endfunction

  function automatic string tag_at(int k);
    if (k < HALF * LP) return "R3";
    if (k < HALF * LP + GRD) return "R4";
    if (k < FLEN) return "R5";
    return "R6";
  endfunction

  task automatic check(string tag, logic [2:0] es, logic [5:0] ec);
    n_chk++;
    if (state !== es || cnt !== ec) begin
      n_bad++;
      $display("FAIL %s: state=%b cnt=%0d expected state=%b cnt=%0d", tag, state, cnt, es, ec);
    end
  endtask

  task automatic idle_dwell(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      check("R9", 3'b000, 6'd0);
    end
  endtask

  // pat: 0 low, 1 high, 2 toggling during the frame (R7); chain starts next frame
  task automatic run_frame(string ftag, bit chain, int pat);
    logic [8:0] e;
    for (int k = 0; k <= FLEN + 1; k++) begin
      @(posedge clk); #2;
      e = exp_at(k);
      check((k == 0) ? "R2" : {ftag, "/", tag_at(k), "/R7"}, e[8:6], e[5:0]);
      if (k == FLEN + 1) new_chirp = chain;
      else new_chirp = (pat == 1) ? 1'b1 : (pat == 2) ? 1'(k % 2) : 1'b0;
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!fin) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1", 3'b000, 6'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    check("R1", 3'b000, 6'd0);
    idle_dwell(4);
    new_chirp = 1'b1;
    run_frame("F1", 1'b1, 1);   // request held high, chains straight on
    run_frame("R8", 1'b0, 2);   // back-to-back frame, toggling request
    idle_dwell(5);
    new_chirp = 1'b1;
    @(posedge clk); #2;         // single-cycle pulse
    check("R2", 3'b001, 6'd0);
    new_chirp = 1'b0;
    for (int k = 1; k <= FLEN + 1; k++) begin
      logic [8:0] e;
      @(posedge clk); #2;
      e = exp_at(k);
      check({"R8/", tag_at(k)}, e[8:6], e[5:0]);
    end
    idle_dwell(3);
    fin = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule